// File: doc/BRIEF.md
# Timer Match Output Controller

This block pairs a free-running 16-bit timer counter with four compare channels. Every channel holds a match value and a single output state bit. Each cycle in which the counter steps forward, every channel compares the counter against its match value. On equality the channel applies its own two-bit action code to its state bit: keep it, force it low, force it high, or invert it. The state bits drive the match outputs. A per-channel PWM bypass input can take over an output pin and stop the action code from touching that channel's state bit.

Software reaches the block through a small word-addressed register port. One control word packs the four state bits and the four action codes. Each channel's match value has its own word, and so do the counter and a DMA enable word. Software can write the state bits directly. When a hit lands in the same cycle as such a write, the channel's action takes precedence. Channels 0 and 1 can each raise a one-cycle DMA request pulse on a hit. Channels 2 and 3 have no DMA path.

Register words by address: 0 is the control word, 1 to 4 hold the match values of channels 0 to 3, 5 is the counter, 6 is the DMA enable word, and 7 reads as zero.

Top module: `tmr_match_ctrl`

## Requirements
- R1: After reset the counter, all match values, all state bits, all action codes and both DMA enables are 0, and every output and every register word reads 0.
- R2: While `cnt_en` is high and the counter word is not being written, the counter rises by one per clock and wraps from 0xFFFF to 0x0000. A write to address 5 loads the counter in place of the step, and a read of address 5 returns the counter.
- R3: The action code of channel i sits in control bits [5+2i:4+2i], i.e. [5:4], [7:6], [9:8] and [11:10]. Code 00 keeps the state bit, 01 clears it, 10 sets it and 11 inverts it. The code is applied at the clock edge where `cnt_en` is high, the counter is not being written, and the counter equals that channel's match value.
- R4: With no hit (`cnt_en` low, or the counter differs from the match value) and no control-word write, a channel's state bit does not change.
- R5: A write to address 0 loads state bits [3:0] from write data bits [3:0]. On a channel that has a hit with a non-00 code in that cycle, the action result, computed from the old state, replaces the written value.
- R6: Control word bits [3:0] read back the state bits and bits [11:4] read back the action codes. Bits [15:12] read 0 and writes to them are dropped.
- R7: While `pwm_mode[i]` is high, `mat_out[i]` follows `pwm_lvl[i]` and hits do not apply the action code to state bit i. While it is low, `mat_out[i]` equals state bit i.
- R8: A hit on channel 0 or 1 whose enable bit (address 6, bits [1:0] for channels 0 and 1) is set raises `dma_req` of that channel for exactly the clock cycle after the hit edge. `dma_req[3:2]` stay 0.
- R9: Writes to addresses 1 to 4 set the match values of channels 0 to 3. Reads return the 16-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter step enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| pwm_mode | input | 4 | Per-channel PWM bypass select |
| pwm_lvl | input | 4 | Per-channel level used during bypass |
| mat_out | output | 4 | Match outputs |
| dma_req | output | 4 | DMA request pulses (only bits 1:0 can be active) |

## Verification
A software load of the state bits and a compare hit can land on the same channel in the same cycle, and so can a counter load and a counter step. The bench forces the first collision directly. It sets the counter to a channel's match value, enables counting, and writes the control word in that one cycle, using a clearing code on one channel and a keep code on another. The action must win on the first channel and the written bit must survive on the second. Random stimulus keeps match values a few counts ahead of the counter, so both collisions recur often, with and without PWM bypass. Every cycle is judged against a cycle-accurate model in the bench.

// File: rtl/tmr_match_pkg.sv
package tmr_match_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_CLR  = 2'b01,
      ACT_SET  = 2'b10,
      ACT_TGL  = 2'b11
   } match_act_e;

   function automatic logic apply_act(input match_act_e act, input logic cur);
      case (act)
         ACT_CLR: apply_act = 1'b0;
         ACT_SET: apply_act = 1'b1;
         ACT_TGL: apply_act = ~cur;
         default: apply_act = cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] tc_o,
   output logic             step_o
);

   assign step_o = cnt_en_i & ~ld_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tc_o <= '0;
      else if (ld_i)   tc_o <= ld_val_i;
      else if (step_o) tc_o <= tc_o + 1'b1;
   end

   // R2: one step per enabled cycle, wrapping naturally
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> tc_o == CNT_W'($past(tc_o) + 1'b1));
   // R2: load overrides stepping
   p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> tc_o == $past(ld_val_i));
   // R2: idle counter holds
   p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && !cnt_en_i) |=> $stable(tc_o));

endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
   import tmr_match_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [CNT_W-1:0] tc_i,
   input  logic             mr_we_i,
   input  logic [CNT_W-1:0] mr_wd_i,
   input  match_act_e       act_i,
   input  logic             em_we_i,
   input  logic             em_wd_i,
   input  logic             dma_en_i,
   input  logic             pwm_mode_i,
   input  logic             pwm_lvl_i,
   output logic [CNT_W-1:0] mr_o,
   output logic             em_o,
   output logic             mat_o,
   output logic             dma_req_o
);

   logic hit;
   logic act_fire;

   assign hit      = step_i && (tc_i == mr_o);
   assign act_fire = hit && !pwm_mode_i && (act_i != ACT_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mr_o <= '0;
      else if (mr_we_i) mr_o <= mr_wd_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        em_o <= 1'b0;
      else if (act_fire) em_o <= apply_act(act_i, em_o);
      else if (em_we_i)  em_o <= em_wd_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_req_o <= 1'b0;
      else        dma_req_o <= hit && dma_en_i;
   end

   assign mat_o = pwm_mode_i ? pwm_lvl_i : em_o;

   // R3: each code's effect on a hit
   p_act_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pwm_mode_i && act_i == ACT_CLR) |=> !em_o);
   p_act_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pwm_mode_i && act_i == ACT_SET) |=> em_o);
   p_act_tgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pwm_mode_i && act_i == ACT_TGL) |=> em_o != $past(em_o));
   // R4: no hit, no write: state holds
   p_no_hit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !em_we_i) |=> $stable(em_o));
   // R5: a write lands unless an action fires
   p_wr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (em_we_i && !act_fire) |=> em_o == $past(em_wd_i));
   // R7: bypass freezes the state bit against hits
   p_pwm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode_i && !em_we_i) |=> $stable(em_o));
   // R8: request pulse follows an enabled hit and nothing else
   p_dma_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && dma_en_i) |=> dma_req_o);
   p_dma_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && dma_en_i) |=> !dma_req_o);

endmodule

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl
   import tmr_match_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_CH  = 4,
   parameter int NUM_DMA = 2,
   localparam int ACT_LO = NUM_CH,
   localparam int CTRL_W = 3 * NUM_CH,
   localparam int DATA_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W,
   localparam int ADDR_W = $clog2(NUM_CH + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] pwm_mode,
   input  logic [NUM_CH-1:0] pwm_lvl,
   output logic [NUM_CH-1:0] mat_out,
   output logic [NUM_CH-1:0] dma_req
);

   localparam logic [ADDR_W-1:0] A_CTRL = '0;
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(NUM_CH + 1);
   localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(NUM_CH + 2);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("tmr_match_ctrl: CNT_W must be within 2..32");
   end
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_num_ch
      $error("tmr_match_ctrl: NUM_CH must be within 1..8");
   end
   if (NUM_DMA < 1 || NUM_DMA > NUM_CH) begin : g_bad_num_dma
      $error("tmr_match_ctrl: NUM_DMA must be within 1..NUM_CH");
   end

   logic [CNT_W-1:0]    tc;
   logic                step;
   logic [2*NUM_CH-1:0] act_q;
   logic [NUM_DMA-1:0]  dma_en_q;
   logic [NUM_CH-1:0]   em;
   logic [CNT_W-1:0]    mr [NUM_CH];
   logic                ctrl_we;

   assign ctrl_we = reg_we && (reg_addr == A_CTRL);

   tmr_counter #(.CNT_W(CNT_W)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en_i (cnt_en),
      .ld_i     (reg_we && (reg_addr == A_CNT)),
      .ld_val_i (reg_wdata[CNT_W-1:0]),
      .tc_o     (tc),
      .step_o   (step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= '0;
      else if (ctrl_we) act_q <= reg_wdata[CTRL_W-1:ACT_LO];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            dma_en_q <= '0;
      else if (reg_we && reg_addr == A_DMA)  dma_en_q <= reg_wdata[NUM_DMA-1:0];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic dma_en_c;
      if (i < NUM_DMA) begin : g_dma
         assign dma_en_c = dma_en_q[i];
      end else begin : g_no_dma
         assign dma_en_c = 1'b0;
         // R8: channels without a DMA path never request
         p_no_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !dma_req[i]);
      end

      tmr_match_chan #(.CNT_W(CNT_W)) i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .step_i     (step),
         .tc_i       (tc),
         .mr_we_i    (reg_we && (reg_addr == ADDR_W'(i + 1))),
         .mr_wd_i    (reg_wdata[CNT_W-1:0]),
         .act_i      (match_act_e'(act_q[2*i +: 2])),
         .em_we_i    (ctrl_we),
         .em_wd_i    (reg_wdata[i]),
         .dma_en_i   (dma_en_c),
         .pwm_mode_i (pwm_mode[i]),
         .pwm_lvl_i  (pwm_lvl[i]),
         .mr_o       (mr[i]),
         .em_o       (em[i]),
         .mat_o      (mat_out[i]),
         .dma_req_o  (dma_req[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) begin
         reg_rdata[NUM_CH-1:0]      = em;
         reg_rdata[CTRL_W-1:ACT_LO] = act_q;
      end else if (reg_addr == A_CNT) begin
         reg_rdata[CNT_W-1:0] = tc;
      end else if (reg_addr == A_DMA) begin
         reg_rdata[NUM_DMA-1:0] = dma_en_q;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(i + 1)) reg_rdata[CNT_W-1:0] = mr[i];
         end
      end
   end

   // R6: the control write lands the action codes exactly
   p_act_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> act_q == $past(reg_wdata[CTRL_W-1:ACT_LO]));

endmodule

// File: tb/test_tmr_match_ctrl.sv
module test_tmr_match_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wd = '0;
   logic [15:0] rdata;
   logic [3:0]  pm = '0;
   logic [3:0]  pl = '0;
   logic [3:0]  mat_out;
   logic [3:0]  dma_req;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [3:0]  m_em = '0;
   logic [7:0]  m_act = '0;
   logic [15:0] m_mr [4] = '{default: '0};
   logic [15:0] m_tc = '0;
   logic [1:0]  m_den = '0;
   logic [3:0]  m_dma = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_match_ctrl i_tmr_match_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .reg_we    (we),
      .reg_addr  (addr),
      .reg_wdata (wd),
      .reg_rdata (rdata),
      .pwm_mode  (pm),
      .pwm_lvl   (pl),
      .mat_out   (mat_out),
      .dma_req   (dma_req)
   );

   function automatic logic [15:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0:    exp_rd = {4'b0, m_act, m_em};
         3'd1:    exp_rd = m_mr[0];
         3'd2:    exp_rd = m_mr[1];
         3'd3:    exp_rd = m_mr[2];
         3'd4:    exp_rd = m_mr[3];
         3'd5:    exp_rd = m_tc;
         3'd6:    exp_rd = {14'b0, m_den};
         default: exp_rd = '0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [2:0] a);
      case (a)
         3'd0, 3'd7: rd_tag = "R6";
         3'd5:       rd_tag = "R2";
         3'd6:       rd_tag = "R8";
         default:    rd_tag = "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // Called at a falling edge with inputs already set; checks, models one edge.
   task automatic step(input string tag);
      logic [3:0] n_em;
      logic [3:0] n_dma;
      logic       ld_tc;
      logic       stp;
      logic       hit;
      logic [1:0] a;
      #1;
      chk(tag != "" ? tag : rd_tag(addr), rdata, exp_rd(addr));
      chk(tag != "" ? tag : ((|pm) ? "R7" : "R3"), {12'b0, mat_out},
          {12'b0, (pm & pl) | (~pm & m_em)});
      chk(tag != "" ? tag : "R8", {12'b0, dma_req}, {12'b0, m_dma});
      ld_tc = we && addr == 3'd5;
      stp   = cnt_en && !ld_tc;
      for (int i = 0; i < 4; i++) begin
         hit = stp && (m_tc == m_mr[i]);
         a   = m_act[2*i +: 2];
         if (hit && !pm[i] && a != 2'b00)
            n_em[i] = (a == 2'b01) ? 1'b0 : (a == 2'b10) ? 1'b1 : ~m_em[i];
         else if (we && addr == 3'd0)
            n_em[i] = wd[i];
         else
            n_em[i] = m_em[i];
         n_dma[i] = hit && (i < 2) && m_den[i];
      end
      m_em  = n_em;
      m_dma = n_dma;
      if (we && addr == 3'd0) m_act = wd[11:4];
      if (we && addr >= 3'd1 && addr <= 3'd4) m_mr[addr - 3'd1] = wd;
      if (we && addr == 3'd6) m_den = wd[1:0];
      if (ld_tc) m_tc = wd;
      else if (cnt_en) m_tc = m_tc + 16'd1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
      we = 1'b1; addr = a; wd = d; cnt_en = 1'b0;
      step(tag);
      we = 1'b0;
   endtask

   task automatic idle(input logic [2:0] a, input logic en, input int n, input string tag);
      we = 1'b0; addr = a; cnt_en = en;
      for (int k = 0; k < n; k++) step(tag);
      cnt_en = 1'b0;
   endtask

   initial begin
      int r;
      r = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every word and output
      for (int k = 0; k < 8; k++) begin
         addr = 3'(k);
         step("R1");
      end

      // R2: counter load, step and wrap
      wr(3'd5, 16'hFFFE, "R2");
      idle(3'd5, 1'b1, 4, "R2");

      // R9: match value writes and readback
      wr(3'd1, 16'h1234, "R9"); idle(3'd1, 1'b0, 1, "R9");
      wr(3'd4, 16'hABCD, "R9"); idle(3'd4, 1'b0, 1, "R9");

      // R6: reserved bits drop, state bits load
      wr(3'd0, 16'hF000, "R6"); idle(3'd0, 1'b0, 1, "R6");
      wr(3'd0, 16'hF00A, "R6"); idle(3'd0, 1'b0, 1, "R6");

      // R3: clear / set / toggle / keep on simultaneous hits
      for (int k = 1; k <= 4; k++) wr(3'(k), 16'h0020, "R3");
      wr(3'd0, 16'h039F, "R3");
      wr(3'd5, 16'h001E, "R3");
      idle(3'd0, 1'b1, 4, "R3");

      // R4: counter sits on the match value but is not stepping
      wr(3'd0, 16'h0FF5, "R4");
      wr(3'd5, 16'h0020, "R4");
      idle(3'd0, 1'b0, 4, "R4");

      // R5: write and hit in the same cycle
      wr(3'd1, 16'h0040, "R5");
      wr(3'd2, 16'h0040, "R5");
      wr(3'd0, 16'h0010, "R5");
      wr(3'd5, 16'h0040, "R5");
      we = 1'b1; addr = 3'd0; wd = 16'h001F; cnt_en = 1'b1;
      step("R5");
      idle(3'd0, 1'b0, 2, "R5");

      // R7: bypass on channel 2 while every code toggles
      pm = 4'b0100; pl = 4'b0100;
      wr(3'd0, 16'h0FF0, "R7");
      wr(3'd3, 16'h0060, "R7");
      wr(3'd5, 16'h005E, "R7");
      idle(3'd0, 1'b1, 4, "R7");
      pl = 4'b0000;
      idle(3'd0, 1'b0, 1, "R7");
      pm = 4'b0000;

      // R8: request pulses, then with channel 1 disabled
      for (int k = 1; k <= 4; k++) wr(3'(k), 16'h0080, "R8");
      wr(3'd6, 16'h0003, "R8");
      wr(3'd5, 16'h007F, "R8");
      idle(3'd6, 1'b1, 3, "R8");
      wr(3'd6, 16'h0001, "R8");
      wr(3'd5, 16'h007F, "R8");
      idle(3'd6, 1'b1, 3, "R8");

      // Random mix
      for (int k = 0; k < 3000; k++) begin
         cnt_en = ($urandom % 4) != 0;
         pm     = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
         pl     = 4'($urandom);
         r      = int'($urandom % 16);
         we     = 1'b1;
         if (r == 0) begin
            addr = 3'd0; wd = 16'($urandom);
         end else if (r == 1 || r == 2) begin
            addr = 3'(1 + $urandom % 4); wd = m_tc + 16'($urandom % 8);
         end else if (r == 3) begin
            addr = 3'd5; wd = 16'($urandom);
         end else if (r == 4) begin
            addr = 3'd6; wd = 16'($urandom);
         end else begin
            we = 1'b0; addr = 3'($urandom); wd = 16'($urandom);
         end
         step("");
      end
      we = 1'b0; cnt_en = 1'b0; pm = '0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule